// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block keeps the interrupt state of a serial port. Eleven interrupt sources (four modem-status changes, receive, transmit, receive timeout and four error conditions) each raise a sticky bit in a raw level register when their set pulse arrives. Software enables sources through a mask register and acknowledges them by writing ones to a clear address. Both the raw bits and the masked bits (raw AND mask) can be read back.

The masked vector fans out to six interrupt lines. Five of them each serve one group of sources. The sixth is the OR of all eleven masked bits. Every line is derived combinationally from the two registers, so a line moves in the same cycle that the register which feeds it changes. The bus protocol in front of the block and the logic that detects each source are outside it. The block sees single-cycle write strobes with a two-bit register select, and a combinational read port.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the raw level and the mask. After reset every interrupt line is low and every read returns zero.
- R2: A write with `wr_sel`=0 loads the mask from `wr_data`. Reading with `rd_sel`=0 returns the mask.
- R3: A set pulse makes its raw bit 1 at the next clock edge, and the bit stays 1 until it is cleared. The bit positions are: modem bits 0 to 3 from `src_ms[0..3]`, receive bit 4, transmit bit 5, timeout bit 6, error bits 7 to 10 from `src_err[0..3]`. Reading with `rd_sel`=1 returns the raw level.
- R4: Every transmit-data write strobe (`src_tdata_wr`) sets raw bit 5.
- R5: Reading with `rd_sel`=2 returns the raw level ANDed with the mask.
- R6: A write with `wr_sel`=3 clears each raw bit whose written bit is 1. The other raw bits keep their value.
- R7: Reading with `rd_sel`=3 always returns zero.
- R8: Writes with `wr_sel`=1 or `wr_sel`=2 change neither the raw level nor the mask.
- R9: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up 1.
- R10: Each line is high exactly when its group has a set bit in the masked vector. The groups are: `irq_ms` bits 0-3, `irq_rx` bit 4, `irq_tx` bit 5, `irq_rt` bit 6, `irq_err` bits 7-10, and `irq_any` all bits. Lines follow changes of the raw level or the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ms | input | 4 | Modem-status set pulses, raw bits 0-3 |
| src_rx | input | 1 | Receive set pulse, raw bit 4 |
| src_tdata_wr | input | 1 | Transmit data register write strobe, sets raw bit 5 |
| src_rt | input | 1 | Receive timeout set pulse, raw bit 6 |
| src_err | input | 4 | Error set pulses, raw bits 7-10 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 raw (ignored), 2 masked (ignored), 3 clear |
| wr_data | input | 11 | Write data |
| rd_sel | input | 2 | Read source: 0 mask, 1 raw, 2 masked, 3 clear (reads zero) |
| rd_data | output | 11 | Read data, combinational on `rd_sel` |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rt | output | 1 | Receive timeout interrupt line |
| irq_ms | output | 1 | Modem-status group interrupt line |
| irq_err | output | 1 | Error group interrupt line |

## Verification
The assertions check the register rules on every cycle. They cover the reset value, the mask load, set bits that stay set, set winning over clear, the clear writes, writes to the read-only addresses leaving both registers alone, the clear address reading zero, and the combined line agreeing with the five group lines. The bench's reference model is needed for the rest: the exact bit position each source lands on, the masked readback, and the membership of each group line. It also covers mask changes that raise or drop lines with no source activity, and long random mixes of overlapping sets and clears.

// File: rtl/uirq_pkg.sv
// Package: shared constants and types for the UART interrupt unit.
// Holds the raw bit layout, the register select codes and the per-line
// group masks. Assumes eleven sources in a fixed order.
package uirq_pkg;

    localparam int MS_LSB   = 0;
    localparam int MS_W     = 4;
    localparam int RX_BIT   = 4;
    localparam int TX_BIT   = 5;
    localparam int RT_BIT   = 6;
    localparam int ERR_LSB  = 7;
    localparam int ERR_W    = 4;
    localparam int NUM_SRC  = ERR_LSB + ERR_W;
    localparam int NUM_LINES = 6;

    // Line indices in the fan-out vector
    localparam int LN_ANY = 0;
    localparam int LN_RX  = 1;
    localparam int LN_TX  = 2;
    localparam int LN_RT  = 3;
    localparam int LN_MS  = 4;
    localparam int LN_ERR = 5;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_RAW  = 2'd1,
        SEL_MSKD = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Builds a contiguous field mask of width w starting at lsb
    function automatic src_vec_t field_mask(int lsb, int w);
        src_vec_t m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i >= lsb && i < lsb + w) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Returns the group of raw bits that drives a given line
    function automatic src_vec_t line_mask(int ln);
        case (ln)
            LN_ANY:  return field_mask(0, NUM_SRC);
            LN_RX:   return field_mask(RX_BIT, 1);
            LN_TX:   return field_mask(TX_BIT, 1);
            LN_RT:   return field_mask(RT_BIT, 1);
            LN_MS:   return field_mask(MS_LSB, MS_W);
            default: return field_mask(ERR_LSB, ERR_W);
        endcase
    endfunction

endpackage

// File: rtl/uirq_level_reg.sv
// Module: raw interrupt level register.
// Each bit is set by its pulse and cleared by a write-one-to-clear strobe.
// When a set and a clear hit the same bit in one cycle, the set wins.
// Assumes the set pulses are already synchronous to clk.
module uirq_level_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] raw_q
);

    logic [W-1:0] clr_eff;

    // Clear bits only count in a cycle that carries a clear write
    always_comb begin
        clr_eff = clr_we ? clr_bits : '0;
    end

    // One flop per source: set has priority over clear
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)            raw_q[b] <= 1'b0;
            else if (set_vec[b])   raw_q[b] <= 1'b1;
            else if (clr_eff[b])   raw_q[b] <= 1'b0;
        end
    end

    // R1: reset empties the level register
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0));

    // R3: a set bit is 1 after the edge
    p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    // R9: set beats a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((set_vec & clr_bits) != '0))
        |=> ((raw_q & $past(set_vec & clr_bits)) == $past(set_vec & clr_bits)));

    // R6: cleared bits without a set are 0, untouched bits hold
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_vec == '0)
        |=> (raw_q == ($past(raw_q) & ~$past(clr_bits))));

endmodule

// File: rtl/uirq_mask_reg.sv
// Module: interrupt enable mask register.
// Loads the whole mask on a write strobe and holds it otherwise.
// Assumes the strobe is already decoded for the mask address.
module uirq_mask_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    // Mask storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= wdata;
    end

    // R2: a load takes the written value
    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mask_q == $past(wdata)));

    // R2: without a load the mask holds
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> $stable(mask_q));

endmodule

// File: rtl/uirq_fanout.sv
// Module: masked status fan-out.
// Forms raw AND mask and reduces it per line through a fixed group mask.
// Purely combinational; assumes the package line order.
module uirq_fanout
    import uirq_pkg::*;
#(
    parameter int W = NUM_SRC,
    parameter int L = NUM_LINES
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic [L-1:0] lines
);

    // Masked status vector
    always_comb begin
        masked = raw & mask;
    end

    // One OR-reduction per line, selected by its group mask
    for (genvar g = 0; g < L; g++) begin : g_line
        localparam src_vec_t GMASK = line_mask(g);
        always_comb begin
            lines[g] = |(masked & GMASK);
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: UART interrupt status and masking unit (top).
// Packs the source pulses into the raw layout, decodes register writes,
// muxes register reads and exposes the six interrupt lines.
// Assumes single-cycle write strobes and a combinational read port.
module uart_irq_ctrl
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MS_W-1:0]    src_ms,
    input  logic               src_rx,
    input  logic               src_tdata_wr,
    input  logic               src_rt,
    input  logic [ERR_W-1:0]   src_err,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [1:0]         rd_sel,
    output logic [NUM_SRC-1:0] rd_data,
    output logic               irq_any,
    output logic               irq_rx,
    output logic               irq_tx,
    output logic               irq_rt,
    output logic               irq_ms,
    output logic               irq_err
);

    src_vec_t             set_vec;
    src_vec_t             raw_q;
    src_vec_t             mask_q;
    src_vec_t             masked;
    logic [NUM_LINES-1:0] lines;
    logic                 mask_we;
    logic                 clr_we;

    // Place each source pulse at its raw bit position
    always_comb begin
        set_vec                       = '0;
        set_vec[MS_LSB +: MS_W]       = src_ms;
        set_vec[RX_BIT]               = src_rx;
        set_vec[TX_BIT]               = src_tdata_wr;
        set_vec[RT_BIT]               = src_rt;
        set_vec[ERR_LSB +: ERR_W]     = src_err;
    end

    // Decode writes; raw and masked addresses have no effect
    always_comb begin
        mask_we = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
        clr_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_CLR);
    end

    uirq_level_reg #(.W(NUM_SRC)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_bits (wr_data),
        .raw_q    (raw_q)
    );

    uirq_mask_reg #(.W(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mask_we),
        .wdata  (wr_data),
        .mask_q (mask_q)
    );

    uirq_fanout #(.W(NUM_SRC), .L(NUM_LINES)) u_fan (
        .raw    (raw_q),
        .mask   (mask_q),
        .masked (masked),
        .lines  (lines)
    );

    // Read multiplexer; the clear address reads as zero
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_MASK: rd_data = mask_q;
            SEL_RAW:  rd_data = raw_q;
            SEL_MSKD: rd_data = masked;
            default:  rd_data = '0;
        endcase
    end

    // Drive the named lines from the fan-out vector
    always_comb begin
        irq_any = lines[LN_ANY];
        irq_rx  = lines[LN_RX];
        irq_tx  = lines[LN_TX];
        irq_rt  = lines[LN_RT];
        irq_ms  = lines[LN_MS];
        irq_err = lines[LN_ERR];
    end

    // R10: the combined line agrees with the five group lines
    p_combined_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_rx | irq_tx | irq_rt | irq_ms | irq_err));

    // R4: a transmit data write leaves the transmit bit set
    p_tx_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_tdata_wr |=> raw_q[TX_BIT]);

    // R8: writes to the read-only addresses change nothing
    p_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2) && set_vec == '0)
        |=> ($stable(raw_q) && $stable(mask_q)));

    // R7: the clear address always reads zero
    p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data == '0));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
// Bench: random plus directed stimulus against a bench-side reference model.
module uart_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   src_ms = '0;
    logic         src_rx = 1'b0;
    logic         src_tdata_wr = 1'b0;
    logic         src_rt = 1'b0;
    logic [3:0]   src_err = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_sel = '0;
    logic [N-1:0] rd_data;
    logic irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int n_checks = 0;
    int n_fail = 0;
    logic [N-1:0] m_raw = '0;
    logic [N-1:0] m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_ms(src_ms), .src_rx(src_rx),
        .src_tdata_wr(src_tdata_wr), .src_rt(src_rt), .src_err(src_err),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    function automatic logic [N-1:0] set_bits();
        return {src_err, src_rt, src_tdata_wr, src_rx, src_ms};
    endfunction

    // Expected lines: {err, ms, rt, tx, rx, any}
    function automatic logic [5:0] exp_lines(logic [N-1:0] r, logic [N-1:0] m);
        logic [N-1:0] v;
        v = r & m;
        return {|v[10:7], |v[3:0], v[6], v[5], v[4], |v};
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Checks all reads and lines against the model; stays in the low phase
    task automatic check_all(string req);
        rd_sel = 2'd0; #1; chk({req, " R2 mask read"}, rd_data, m_mask);
        rd_sel = 2'd1; #1; chk({req, " R3 raw read"}, rd_data, m_raw);
        rd_sel = 2'd2; #1; chk({req, " R5 masked read"}, rd_data, m_raw & m_mask);
        rd_sel = 2'd3; #1; chk({req, " R7 clear read"}, rd_data, '0);
        chk({req, " R10 lines"},
            {5'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_any},
            {5'd0, exp_lines(m_raw, m_mask)});
    endtask

    task automatic idle_inputs();
        src_ms = '0; src_rx = 0; src_tdata_wr = 0; src_rt = 0; src_err = '0;
        wr_en = 0; wr_sel = '0; wr_data = '0;
    endtask

    // One clock: model follows the rules at the edge, then checks at negedge
    task automatic cycle(string req);
        logic [N-1:0] clr;
        @(posedge clk);
        if (!rst_n) begin
            m_raw = '0; m_mask = '0;
        end else begin
            clr = (wr_en && wr_sel == 2'd3) ? wr_data : '0;
            if (wr_en && wr_sel == 2'd0) m_mask = wr_data;
            m_raw = (m_raw & ~clr) | set_bits();
        end
        @(negedge clk);
        check_all(req);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state, with activity on the inputs held off by reset
        rst_n = 0;
        src_rx = 1; wr_en = 1; wr_sel = 2'd0; wr_data = '1;
        cycle("R1 reset");
        rst_n = 0;
        cycle("R1 reset");
        rst_n = 1;
        cycle("R1 after reset");

        // R2: mask load
        wr_en = 1; wr_sel = 2'd0; wr_data = 11'h7FF;
        cycle("R2 mask all");

        // R3: each source lands on its bit
        src_ms = 4'b0101; src_err = 4'b1000;
        cycle("R3 set ms/err");
        src_rt = 1; src_rx = 1;
        cycle("R3 set rt/rx");

        // R4: transmit data write
        src_tdata_wr = 1;
        cycle("R4 tx write");

        // R8: writes to raw and masked addresses ignored
        wr_en = 1; wr_sel = 2'd1; wr_data = '0;
        cycle("R8 raw write");
        wr_en = 1; wr_sel = 2'd2; wr_data = 11'h000;
        cycle("R8 masked write");

        // R10: mask change alone moves lines
        wr_en = 1; wr_sel = 2'd0; wr_data = 11'h020;
        cycle("R10 mask tx only");
        wr_en = 1; wr_sel = 2'd0; wr_data = 11'h400;
        cycle("R10 mask one err");

        // R6: clear some bits
        wr_en = 1; wr_sel = 2'd3; wr_data = 11'h431;
        cycle("R6 w1c");

        // R9: set wins over same-cycle clear
        wr_en = 1; wr_sel = 2'd3; wr_data = 11'h7FF; src_rx = 1; src_err = 4'b0001;
        cycle("R9 set wins");
        wr_en = 1; wr_sel = 2'd3; wr_data = 11'h7FF;
        cycle("R6 clear all");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) src_ms = 4'($urandom);
            src_rx       = (r[7:4] == 4'd1);
            src_tdata_wr = (r[11:8] == 4'd2);
            src_rt       = (r[15:12] == 4'd3);
            if (r[19:16] == 4'd4) src_err = 4'($urandom);
            wr_en   = r[20] | r[21];
            wr_sel  = 2'($urandom);
            wr_data = 11'($urandom);
            if (r[31:28] == 4'd0) rst_n = 0;
            cycle("R3/R5/R6/R9/R10 random");
            rst_n = 1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule